// File: doc/BRIEF.md
# Parallel Flash Byte Programming Sequencer

This block sits on the programmer side of a parallel-programmable flash device and writes a stream of address/data pairs into it, one byte at a time. Each pair arrives on a valid/ready input. For each pair the sequencer puts the address on the device bus, then the data. It then selects the program control combination and brings up the program-enable qualifier. After a setup interval it issues a single active-low program strobe.

Once the strobe ends, the sequencer waits for the device's self-timed write to finish. A run-time input selects how completion is detected. In polling mode it reads back the written address until bit 7 shows its true value rather than the complement. In ready/busy mode it waits for the busy line to go low and then return high. If neither happens within a cycle budget derived from a 50 µs worst-case write time, the write is treated as failed.

An optional read-back compares the full byte after completion. Any failure latches an error flag and the failing address, stops the stream, drops program-enable and releases the bus. The end of a stream is marked by the pair flagged as last. That byte also drops program-enable and releases the bus, then raises `done`.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `inReady` is 1, `devVpp` 0, `devProgN` 1, `devDataOe` 0, `devBusEn` 0, and `done`, `errTimeout` and `errVerify` are all 0.
- R2: A pair is taken on a rising clock edge where `inValid` and `inReady` are both 1. `inReady` is 1 only while the sequencer is idle and no error is latched.
- R3: While `devProgN` is 0, `devDataOe`, `devModeProg` and `devVpp` are all 1, and `devAddr` and `devDataOut` do not change.
- R4: Each accepted pair produces exactly one strobe, low for exactly PULSE_CYC cycles. For the first byte of a stream, `devVpp` is high for exactly SETUP_CYC+1 cycles before the strobe falls.
- R5: Polling mode (`cfgPollMode`=1) treats the write as done when a read of the written address returns bit 7 equal to the written bit 7. No new strobe is issued while the device is still busy.
- R6: Ready/busy mode (`cfgPollMode`=0) treats the write as done when `devRdyBsy` is seen 1 after having been seen 0 since the strobe fell.
- R7: Completion must be seen within TIMEOUT_CYC = CLK_MHZ*WRITE_US cycles. The count starts with the cycle in which the strobe returns high. Completion seen in the last of these cycles counts as success. Otherwise `errTimeout` is set and `errAddr` holds the address.
- R8: With `cfgVerify`=1, all 8 bits are read back after completion and compared with the written data. A mismatch sets `errVerify` and captures the address in `errAddr`.
- R9: With `cfgVerify`=0, a stored byte that differs from the written data in bits 6..0 causes no error, and the stream completes.
- R10: After the byte flagged `inLast` completes, `devVpp`, `devDataOe` and `devBusEn` are 0 and `done` is 1. `done` clears when the next pair is accepted.
- R11: Once an error is latched, `devVpp`, `devDataOe`, `devBusEn` and `inReady` stay 0 and no further pair is accepted until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgPollMode | input | 1 | 1: bit-7 polling, 0: ready/busy line |
| cfgVerify | input | 1 | 1: full-byte read-back after each write |
| inValid | input | 1 | Input pair valid |
| inReady | output | 1 | Sequencer can take a pair |
| inAddr | input | ADDR_W | Target address |
| inData | input | 8 | Byte to program |
| inLast | input | 1 | Marks the final pair of a stream |
| devAddr | output | ADDR_W | Device address bus |
| devDataOut | output | 8 | Data driven to the device |
| devDataOe | output | 1 | Drive enable for the data bus |
| devDataIn | input | 8 | Data returned by the device |
| devModeProg | output | 1 | 1: program control combination, 0: read |
| devVpp | output | 1 | Program-enable qualifier request |
| devProgN | output | 1 | Program strobe, active low |
| devRead | output | 1 | Read request during completion wait and verify |
| devRdyBsy | input | 1 | Device ready (1) / busy (0) |
| devBusEn | output | 1 | Drive enable for address and control lines |
| done | output | 1 | Stream finished without error |
| errTimeout | output | 1 | Write did not complete in time |
| errVerify | output | 1 | Read-back mismatch |
| errAddr | output | ADDR_W | Address of the failing byte |

## Verification
Write completion and expiry of the timeout budget can fall in the same cycle, the last cycle of the wait window. The bench drives the ready/busy line by hand. It pulls the line low when the strobe falls. It then counts clock cycles from the strobe's rising edge and releases the line either in the last allowed cycle or one cycle later. The first case must end with `done` and no timeout flag. The second must end with `errTimeout`, the captured address and a released bus.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_MODE,
    ST_VPP,
    ST_SETUP,
    ST_PULSE,
    ST_WAIT,
    ST_CHECK,
    ST_FAULT
  } seqState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadPair;
    logic cntClr;
    logic cntInc;
    logic clrBusySeen;
    logic setErrTimeout;
    logic setErrVerify;
  } dpCtrl_t;

endpackage

// File: rtl/flash_prog_dp.sv
module flash_prog_dp
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SETUP_CYC   = 4,
  parameter int PULSE_CYC   = 3,
  parameter int TIMEOUT_CYC = 12500
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic              watchBusy,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [7:0]        inData,
  input  logic              inLast,
  input  logic [7:0]        devDataIn,
  input  logic              devRdyBsy,
  output logic [ADDR_W-1:0] addrQ,
  output logic [7:0]        dataQ,
  output logic              lastQ,
  output logic [ADDR_W-1:0] errAddr,
  output logic              setupDone,
  output logic              pulseDone,
  output logic              waitExpired,
  output logic              pollMatch,
  output logic              rdyDone,
  output logic              verifyMatch
);

  localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_CNT = (MAX_A > TIMEOUT_CYC) ? MAX_A : TIMEOUT_CYC;
  localparam int CNT_W = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0] cnt;
  logic             busySeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      lastQ <= 1'b0;
    end else if (ctrl.loadPair) begin
      addrQ <= inAddr;
      dataQ <= inData;
      lastQ <= inLast;
    end
  end

  // Shared interval counter: setup, pulse width and completion window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (ctrl.cntClr) cnt <= '0;
    else if (ctrl.cntInc) cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busySeen <= 1'b0;
    else if (ctrl.clrBusySeen) busySeen <= 1'b0;
    else if (watchBusy && !devRdyBsy) busySeen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errAddr <= '0;
    else if (ctrl.setErrTimeout || ctrl.setErrVerify) errAddr <= addrQ;
  end

  assign setupDone   = (cnt == CNT_W'(SETUP_CYC - 1));
  assign pulseDone   = (cnt == CNT_W'(PULSE_CYC - 1));
  assign waitExpired = (cnt == CNT_W'(TIMEOUT_CYC - 1));
  assign pollMatch   = (devDataIn[7] == dataQ[7]);
  assign rdyDone     = busySeen && devRdyBsy;
  assign verifyMatch = (devDataIn == dataQ);

endmodule

// File: rtl/flash_prog_ctl.sv
module flash_prog_ctl
  import flash_prog_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgPollMode,
  input  logic    cfgVerify,
  input  logic    inValid,
  input  logic    lastQ,
  input  logic    setupDone,
  input  logic    pulseDone,
  input  logic    waitExpired,
  input  logic    pollMatch,
  input  logic    rdyDone,
  input  logic    verifyMatch,
  output dpCtrl_t ctrl,
  output logic    watchBusy,
  output logic    inReady,
  output logic    devBusEn,
  output logic    devDataOe,
  output logic    devModeProg,
  output logic    devVpp,
  output logic    devProgN,
  output logic    devRead,
  output logic    done,
  output logic    errTimeout,
  output logic    errVerify
);

  seqState_t state, nxt;
  logic streamActive;
  logic setStream, endStream, setDone, clrDone;
  logic writeDone;

  assign writeDone = cfgPollMode ? pollMatch : rdyDone;

  always_comb begin
    nxt       = state;
    ctrl      = '0;
    setStream = 1'b0;
    endStream = 1'b0;
    setDone   = 1'b0;
    clrDone   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (inValid) begin
          ctrl.loadPair = 1'b1;
          clrDone       = 1'b1;
          nxt           = ST_ADDR;
        end
      end
      ST_ADDR: nxt = ST_DATA;
      ST_DATA: nxt = ST_MODE;
      ST_MODE: nxt = ST_VPP;
      ST_VPP: begin
        setStream   = 1'b1;
        ctrl.cntClr = 1'b1;
        nxt         = ST_SETUP;
      end
      ST_SETUP: begin
        if (setupDone) begin
          ctrl.cntClr      = 1'b1;
          ctrl.clrBusySeen = 1'b1;
          nxt              = ST_PULSE;
        end else begin
          ctrl.cntInc = 1'b1;
        end
      end
      ST_PULSE: begin
        if (pulseDone) begin
          ctrl.cntClr = 1'b1;
          nxt         = ST_WAIT;
        end else begin
          ctrl.cntInc = 1'b1;
        end
      end
      ST_WAIT: begin
        if (writeDone) begin
          if (cfgVerify) begin
            nxt = ST_CHECK;
          end else begin
            nxt       = ST_IDLE;
            endStream = lastQ;
            setDone   = lastQ;
          end
        end else if (waitExpired) begin
          ctrl.setErrTimeout = 1'b1;
          endStream          = 1'b1;
          nxt                = ST_FAULT;
        end else begin
          ctrl.cntInc = 1'b1;
        end
      end
      ST_CHECK: begin
        if (verifyMatch) begin
          nxt       = ST_IDLE;
          endStream = lastQ;
          setDone   = lastQ;
        end else begin
          ctrl.setErrVerify = 1'b1;
          endStream         = 1'b1;
          nxt               = ST_FAULT;
        end
      end
      ST_FAULT: nxt = ST_FAULT;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      streamActive <= 1'b0;
      done         <= 1'b0;
      errTimeout   <= 1'b0;
      errVerify    <= 1'b0;
    end else begin
      state <= nxt;
      if (endStream) streamActive <= 1'b0;
      else if (setStream) streamActive <= 1'b1;
      if (setDone) done <= 1'b1;
      else if (clrDone) done <= 1'b0;
      if (ctrl.setErrTimeout) errTimeout <= 1'b1;
      if (ctrl.setErrVerify) errVerify <= 1'b1;
    end
  end

  assign inReady     = (state == ST_IDLE);
  assign watchBusy   = (state == ST_PULSE) || (state == ST_WAIT);
  assign devBusEn    = streamActive || ((state != ST_IDLE) && (state != ST_FAULT));
  assign devDataOe   = (state == ST_DATA) || (state == ST_MODE) || (state == ST_VPP) ||
                       (state == ST_SETUP) || (state == ST_PULSE);
  assign devModeProg = (state == ST_MODE) || (state == ST_VPP) ||
                       (state == ST_SETUP) || (state == ST_PULSE);
  assign devVpp      = streamActive || (state == ST_VPP);
  assign devProgN    = (state != ST_PULSE);
  assign devRead     = (state == ST_WAIT) || (state == ST_CHECK);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int SETUP_CYC = 4,
  parameter int PULSE_CYC = 3,
  parameter int CLK_MHZ   = 250,
  parameter int WRITE_US  = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgPollMode,
  input  logic              cfgVerify,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [7:0]        inData,
  input  logic              inLast,
  output logic [ADDR_W-1:0] devAddr,
  output logic [7:0]        devDataOut,
  output logic              devDataOe,
  input  logic [7:0]        devDataIn,
  output logic              devModeProg,
  output logic              devVpp,
  output logic              devProgN,
  output logic              devRead,
  input  logic              devRdyBsy,
  output logic              devBusEn,
  output logic              done,
  output logic              errTimeout,
  output logic              errVerify,
  output logic [ADDR_W-1:0] errAddr
);

  localparam int TIMEOUT_CYC = CLK_MHZ * WRITE_US;

  dpCtrl_t ctrl;
  logic watchBusy, lastQ;
  logic setupDone, pulseDone, waitExpired, pollMatch, rdyDone, verifyMatch;

  flash_prog_ctl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgPollMode (cfgPollMode),
    .cfgVerify   (cfgVerify),
    .inValid     (inValid),
    .lastQ       (lastQ),
    .setupDone   (setupDone),
    .pulseDone   (pulseDone),
    .waitExpired (waitExpired),
    .pollMatch   (pollMatch),
    .rdyDone     (rdyDone),
    .verifyMatch (verifyMatch),
    .ctrl        (ctrl),
    .watchBusy   (watchBusy),
    .inReady     (inReady),
    .devBusEn    (devBusEn),
    .devDataOe   (devDataOe),
    .devModeProg (devModeProg),
    .devVpp      (devVpp),
    .devProgN    (devProgN),
    .devRead     (devRead),
    .done        (done),
    .errTimeout  (errTimeout),
    .errVerify   (errVerify)
  );

  flash_prog_dp #(
    .ADDR_W      (ADDR_W),
    .SETUP_CYC   (SETUP_CYC),
    .PULSE_CYC   (PULSE_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .watchBusy   (watchBusy),
    .inAddr      (inAddr),
    .inData      (inData),
    .inLast      (inLast),
    .devDataIn   (devDataIn),
    .devRdyBsy   (devRdyBsy),
    .addrQ       (devAddr),
    .dataQ       (devDataOut),
    .lastQ       (lastQ),
    .errAddr     (errAddr),
    .setupDone   (setupDone),
    .pulseDone   (pulseDone),
    .waitExpired (waitExpired),
    .pollMatch   (pollMatch),
    .rdyDone     (rdyDone),
    .verifyMatch (verifyMatch)
  );

endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk #(
  parameter int ADDR_W    = 13,
  parameter int PULSE_CYC = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic [ADDR_W-1:0] devAddr,
  input logic [7:0]        devDataOut,
  input logic              devDataOe,
  input logic              devModeProg,
  input logic              devVpp,
  input logic              devProgN,
  input logic              devBusEn,
  input logic              done,
  input logic              errTimeout,
  input logic              errVerify,
  input logic [ADDR_W-1:0] errAddr
);

  localparam int LW = $clog2(PULSE_CYC + 2);
  logic [LW-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= '0;
    else if (!devProgN) lowCnt <= (lowCnt == LW'(PULSE_CYC + 1)) ? lowCnt : lowCnt + LW'(1);
    else lowCnt <= '0;
  end

  assert_strobe_qualified_R3: assert property (@(posedge clk) disable iff (!rstN)
    !devProgN |-> (devVpp && devModeProg && devDataOe));

  assert_strobe_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!devProgN && !$past(devProgN)) |-> ($stable(devAddr) && $stable(devDataOut)));

  assert_pulse_limit_R4: assert property (@(posedge clk) disable iff (!rstN)
    !devProgN |-> (lowCnt < LW'(PULSE_CYC)));

  assert_fault_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (errTimeout || errVerify) |-> (!devVpp && !devDataOe && !devBusEn && !inReady));

  assert_err_addr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(errTimeout || errVerify) |-> $stable(errAddr));

  assert_done_released_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!devVpp && !devBusEn && !errTimeout && !errVerify));

endmodule

bind flash_prog_seq flash_prog_chk #(
  .ADDR_W    (ADDR_W),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inReady     (inReady),
  .devAddr     (devAddr),
  .devDataOut  (devDataOut),
  .devDataOe   (devDataOe),
  .devModeProg (devModeProg),
  .devVpp      (devVpp),
  .devProgN    (devProgN),
  .devBusEn    (devBusEn),
  .done        (done),
  .errTimeout  (errTimeout),
  .errVerify   (errVerify),
  .errAddr     (errAddr)
);

// File: tb/tb_flash_prog_seq.sv
`timescale 1ns/1ps
module tb_flash_prog_seq;

  localparam int AW = 13;
  localparam int SETUP = 4;
  localparam int PULSE = 3;
  localparam int TMO = 250 * 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgPollMode = 1'b1, cfgVerify = 1'b1;
  logic inValid = 1'b0, inLast = 1'b0;
  logic [AW-1:0] inAddr = '0;
  logic [7:0] inData = '0;
  logic inReady, devDataOe, devModeProg, devVpp, devProgN, devRead, devBusEn;
  logic done, errTimeout, errVerify;
  logic [AW-1:0] devAddr, errAddr;
  logic [7:0] devDataOut, devDataIn;
  logic devRdyBsy;

  always #2 clk = ~clk;

  flash_prog_seq #(.ADDR_W(AW), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE)) dut (
    .clk(clk), .rstN(rstN), .cfgPollMode(cfgPollMode), .cfgVerify(cfgVerify),
    .inValid(inValid), .inReady(inReady), .inAddr(inAddr), .inData(inData), .inLast(inLast),
    .devAddr(devAddr), .devDataOut(devDataOut), .devDataOe(devDataOe), .devDataIn(devDataIn),
    .devModeProg(devModeProg), .devVpp(devVpp), .devProgN(devProgN), .devRead(devRead),
    .devRdyBsy(devRdyBsy), .devBusEn(devBusEn), .done(done), .errTimeout(errTimeout),
    .errVerify(errVerify), .errAddr(errAddr)
  );

  // Device model
  logic [7:0] mem [64];
  logic mdlBusy = 1'b0;
  int busyLeft = 0, busyLen = 20;
  logic [5:0] wAddr = '0;
  logic [7:0] wData = '0;
  bit corruptEn = 1'b0;
  logic [5:0] corruptAddr = '0;
  bit manualRdy = 1'b0;
  logic rdyVal = 1'b1;
  int strobes = 0, firstSetup = 0, vppRun = 0, lowRun = 0;
  int badWidth = 0, badQual = 0, strobeBusy = 0;
  logic prevProgN = 1'b1;
  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;

  assign devDataIn = (mdlBusy && devAddr[5:0] == wAddr) ? {~wData[7], 7'h2A} : mem[devAddr[5:0]];
  assign devRdyBsy = manualRdy ? rdyVal : !mdlBusy;

  always @(negedge clk) begin
    if (!devProgN && prevProgN) begin
      strobes++;
      if (strobes == 1) firstSetup = vppRun;
      if (mdlBusy) strobeBusy++;
      if (!(devVpp && devModeProg && devDataOe)) badQual++;
      wAddr = devAddr[5:0];
      wData = devDataOut;
      mem[devAddr[5:0]] = (corruptEn && devAddr[5:0] == corruptAddr) ? devDataOut ^ 8'h01 : devDataOut;
      mdlBusy = 1'b1;
      busyLeft = busyLen;
    end else if (mdlBusy) begin
      busyLeft--;
      if (busyLeft <= 0) mdlBusy = 1'b0;
    end
    if (!devProgN) lowRun++;
    else if (lowRun != 0) begin
      if (lowRun != PULSE) badWidth++;
      lowRun = 0;
    end
    if (!devVpp) vppRun = 0;
    else if (devProgN) vppRun++;
    prevProgN = devProgN;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    inValid = 1'b0;
    manualRdy = 1'b0;
    rdyVal = 1'b1;
    corruptEn = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    mdlBusy = 1'b0;
    strobes = 0; firstSetup = 0; badWidth = 0; badQual = 0; strobeBusy = 0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendByte(input logic [AW-1:0] a, input logic [7:0] d, input bit last, output bit acc);
    inAddr = a; inData = d; inLast = last; inValid = 1'b1;
    acc = 1'b0;
    for (int i = 0; i < 400 && !acc; i++) begin
      if (inReady) acc = 1'b1;
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 20000 && !(done || errTimeout || errVerify); i++) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    check(inReady == 1'b1, "R1 inReady", inReady, 1);
    check(devVpp == 1'b0 && devProgN == 1'b1 && devDataOe == 1'b0 && devBusEn == 1'b0,
          "R1 device lines", {devVpp, devProgN, devDataOe, devBusEn}, 4'b0100);
    check({done, errTimeout, errVerify} == 3'b000, "R1 status", {done, errTimeout, errVerify}, 0);
  endtask

  task automatic testPollStream();
    bit acc;
    doReset();
    cfgPollMode = 1'b1; cfgVerify = 1'b1; busyLen = 20;
    sendByte(13'h005, 8'hA7, 1'b0, acc);
    check(acc, "R2 accept first", acc, 1);
    sendByte(13'h006, 8'h3C, 1'b0, acc);
    sendByte(13'h007, 8'h80, 1'b1, acc);
    waitEnd();
    @(negedge clk);
    check(done && !errTimeout && !errVerify, "R5 poll stream done", {done, errTimeout, errVerify}, 3'b100);
    check(mem[5] == 8'hA7 && mem[6] == 8'h3C && mem[7] == 8'h80, "R8 stored bytes", mem[6], 8'h3C);
    check(strobes == 3, "R4 one strobe per byte", strobes, 3);
    check(badWidth == 0, "R4 pulse width", badWidth, 0);
    check(firstSetup == SETUP + 1, "R4 setup before strobe", firstSetup, SETUP + 1);
    check(badQual == 0, "R3 strobe qualified", badQual, 0);
    check(strobeBusy == 0, "R5 no strobe while busy", strobeBusy, 0);
    check(!devVpp && !devDataOe && !devBusEn, "R10 released", {devVpp, devDataOe, devBusEn}, 0);
    sendByte(13'h008, 8'h11, 1'b1, acc);
    check(done == 1'b0, "R10 done clears on accept", done, 0);
    waitEnd();
    @(negedge clk);
    check(done && mem[8] == 8'h11, "R10 second stream", mem[8], 8'h11);
  endtask

  task automatic testRdyStream();
    bit acc;
    doReset();
    cfgPollMode = 1'b0; cfgVerify = 1'b0; busyLen = 30;
    sendByte(13'h010, 8'h11, 1'b0, acc);
    sendByte(13'h011, 8'hEE, 1'b1, acc);
    waitEnd();
    @(negedge clk);
    check(done && !errTimeout, "R6 rdy stream done", {done, errTimeout}, 2'b10);
    check(strobeBusy == 0, "R6 waits for ready", strobeBusy, 0);
    check(mem[16] == 8'h11 && mem[17] == 8'hEE, "R6 stored", mem[17], 8'hEE);
  endtask

  task automatic testVerifyFail();
    bit acc;
    doReset();
    cfgPollMode = 1'b1; cfgVerify = 1'b1; busyLen = 15;
    corruptEn = 1'b1; corruptAddr = 6'h21;
    sendByte(13'h020, 8'h5A, 1'b0, acc);
    sendByte(13'h021, 8'hC3, 1'b0, acc);
    waitEnd();
    @(negedge clk);
    check(errVerify == 1'b1, "R8 mismatch flagged", errVerify, 1);
    check(errAddr == 13'h021, "R8 failing address", errAddr, 13'h021);
    sendByte(13'h022, 8'h77, 1'b1, acc);
    check(!acc && !inReady, "R11 stream stopped", acc, 0);
    check(mem[34] == 8'hFF && strobes == 2, "R11 no further write", mem[34], 8'hFF);
    check(!devVpp && !devDataOe && !devBusEn, "R11 released", {devVpp, devDataOe, devBusEn}, 0);
  endtask

  task automatic testVerifyOff();
    bit acc;
    doReset();
    cfgPollMode = 1'b1; cfgVerify = 1'b0; busyLen = 15;
    corruptEn = 1'b1; corruptAddr = 6'h30;
    sendByte(13'h030, 8'h42, 1'b1, acc);
    waitEnd();
    @(negedge clk);
    check(done && !errVerify, "R9 no compare", {done, errVerify}, 2'b10);
    check(mem[48] == 8'h43, "R9 stored differs", mem[48], 8'h43);
  endtask

  task automatic testTimeout(input int relAfter, input bit expectFail);
    bit acc;
    doReset();
    cfgPollMode = 1'b0; cfgVerify = 1'b0;
    manualRdy = 1'b1; rdyVal = 1'b1;
    sendByte(13'h040, 8'h5A, 1'b1, acc);
    @(negedge devProgN);
    rdyVal = 1'b0;
    @(posedge devProgN);
    repeat (relAfter) @(negedge clk);
    rdyVal = 1'b1;
    waitEnd();
    @(negedge clk);
    if (expectFail) begin
      check(errTimeout && !done, "R7 late ready times out", {errTimeout, done}, 2'b10);
      check(errAddr == 13'h040, "R7 timeout address", errAddr, 13'h040);
      check(!devVpp && !devBusEn, "R11 released on timeout", {devVpp, devBusEn}, 0);
    end else begin
      check(done && !errTimeout, "R7 ready in last cycle", {done, errTimeout}, 2'b10);
    end
  endtask

  initial begin
    testReset();
    testPollStream();
    testRdyStream();
    testVerifyFail();
    testVerifyOff();
    testTimeout(TMO, 1'b0);
    testTimeout(TMO + 1, 1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule